// File: doc/BRIEF.md
# PCM-30 Frame Alignment Controller

This block sits on the receive side of a 2.048 Mbit/s PCM-30 route. It takes one serial bit per route-clock rising edge and finds where each 256-bit frame (32 slots of 8 bits) begins. Frames alternate between two kinds. One carries a seven-bit alignment word in slot 0. The other carries a service word whose second bit must be 1. The controller hunts for the alignment word, confirms the candidate over the next two frames and then tracks alignment. It has three separate state groups: a confirmation count, a count of alignment-word errors and a count of service-word errors.

While aligned, it gives the position of the bit currently on `din` (bit within slot, slot within frame, and whether the frame carries the alignment word) for a downstream buffer write side. Once per two frames it raises a sync pulse. It stretches a fault pulse over a fixed number of clocks when the alignment word is corrupted, and it raises a loss flag while alignment is not held. It also extracts the far-end alarm bit from the service word.

States: `ST_HUNT` (search at every bit), `ST_GOT_FAS` (one word seen, waiting for the service word), `ST_GOT_SW` (service word seen, waiting for the second word), `ST_LOCK0`/`ST_LOCK1`/`ST_LOCK2` (aligned, with zero, one or two consecutive bad alignment words). The service-word group has `SW_OK`, `SW_ERR1` and `SW_ERR2`. Transitions are as follows. `ST_HUNT`→`ST_GOT_FAS` on a word match at any bit. `ST_GOT_FAS`→`ST_GOT_SW` when the service bit is good, otherwise →`ST_HUNT`. `ST_GOT_SW`→`ST_LOCK0` when the word is good, otherwise →`ST_HUNT`. Any lock state →`ST_LOCK0` on a good word. `ST_LOCK0`→`ST_LOCK1`→`ST_LOCK2`→`ST_HUNT` on successive bad words. Any lock state →`ST_HUNT` when the service group reaches `SW_ERR2`. In the service group, a good service word →`SW_OK` and a bad one steps `SW_OK`→`SW_ERR1`→`SW_ERR2`. The service group returns to `SW_OK` whenever the main group is not locked.

Top module: `frame_aligner`

## Requirements
- R1: While `rst_n` is low and straight after it, `lof`=1, `sync_pulse`=0, `fault_pulse`=0, `dist_alarm`=0, `slot_idx`=0, `bit_idx`=0, `fas_frame`=0.
- R2: Bits of a slot are numbered 0 to 7 in arrival order. In hunt, the bit positions are checked one after another. When the bits at slot positions 1..7, ending with the bit just received, equal 0,0,1,1,0,1,1, the next bit is taken as slot 1, bit 0 of a frame with `fas_frame`=1.
- R3: Alignment is declared, with `lof` falling, only after three checks in a row: the word, then a service word with position-1 bit = 1 in the next frame, then a good word in the frame after that. `lof` falls on the edge that samples the last bit of slot 0 of that third frame. Any failed check returns to hunt, and the search resumes from the next incoming bit.
- R4: While aligned, `sync_pulse` is high for exactly one bit time, while `din` carries slot 31, bit 7 of a frame with `fas_frame`=0. It is never high while `lof`=1.
- R5: While aligned, an alignment word with any bit error raises `fault_pulse` for exactly 4 clocks, starting while `din` carries slot 1, bit 0 of that frame.
- R6: While `lof`=1, one 4-clock fault pulse starts at the slot-0 end of every frame with `fas_frame`=1, which is once per 512 bits. The one exception is the check that confirms alignment.
- R7: Three bad alignment words in a row (counted over alternate frames) set `lof`. A good word in between restarts the count.
- R8: Two bad service words in a row (position-1 bit = 0) set `lof`. A good service word in between restarts the count.
- R9: While aligned, at the end of slot 0 of each frame with `fas_frame`=0, `dist_alarm` takes the bit at slot-0 position 2. Frames with `fas_frame`=1 leave it unchanged, and it is 0 whenever `lof`=1.
- R10: While aligned, (`slot_idx`, `bit_idx`) advance by one per clock and wrap from (31,7) to (0,0). `fas_frame` toggles at each wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Route clock; `din` is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Serial PCM-30 route data |
| bit_idx | output | 3 | Bit position within the slot of the bit now on `din` |
| slot_idx | output | 5 | Slot position within the frame of the bit now on `din` |
| fas_frame | output | 1 | 1 when the current frame carries the alignment word |
| sync_pulse | output | 1 | One-bit marker before slot 0 of alignment-word frames |
| fault_pulse | output | 1 | Stretched fault indication |
| lof | output | 1 | Loss of frame alignment |
| dist_alarm | output | 1 | Far-end alarm bit from the last service word |

## Verification
The position outputs and `sync_pulse` describe the bit currently on `din`, so they are checked in the same bit time in which that bit is driven. `lof`, `dist_alarm` and the start of `fault_pulse` change on the edge that samples slot 0, bit 7. They are therefore first visible while slot 1, bit 0 is driven, and the bench reads `lof` and `dist_alarm` at the last bit of the frame. It records the index of the first fault sample and the number of high samples, so that both the start bit and the four-clock length are compared.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;

    // Main alignment group: hunt/confirmation steps, then locked with an
    // alignment-word error count.
    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_GOT_FAS = 3'd1,
        ST_GOT_SW  = 3'd2,
        ST_LOCK0   = 3'd3,
        ST_LOCK1   = 3'd4,
        ST_LOCK2   = 3'd5
    } align_state_t;

    // Service-word error group, active only while locked.
    typedef enum logic [1:0] {
        SW_OK   = 2'd0,
        SW_ERR1 = 2'd1,
        SW_ERR2 = 2'd2
    } sw_state_t;

    function automatic logic is_locked(input align_state_t s);
        return (s == ST_LOCK0) || (s == ST_LOCK1) || (s == ST_LOCK2);
    endfunction

endpackage

// File: rtl/fa_ts0_window.sv
// Sliding window over the last bits received. Flags an alignment-word match
// and exposes the service and far-alarm bits for the bit now on din.
module fa_ts0_window #(
    parameter int                   SLOT_BITS = 8,
    parameter logic [SLOT_BITS-2:0] FAS_WORD  = 7'b0011011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fas_hit,
    output logic sw_good,
    output logic alarm_bit
);
    localparam int HIST = SLOT_BITS - 2;

    logic [HIST-1:0]      hist_q;
    logic [SLOT_BITS-2:0] win;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= {hist_q[HIST-2:0], din};
        end
    end

    // win[SLOT_BITS-2] is slot position 1; din is position SLOT_BITS-1.
    assign win       = {hist_q, din};
    assign fas_hit   = (win == FAS_WORD);
    assign sw_good   = win[SLOT_BITS-2];
    assign alarm_bit = win[SLOT_BITS-3];
endmodule

// File: rtl/fa_position.sv
// Bit / slot / frame-parity counters for the bit now on din.
module fa_position #(
    parameter int  SLOTS     = 32,
    parameter int  SLOT_BITS = 8,
    localparam int BW        = $clog2(SLOT_BITS),
    localparam int SW        = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] slot_idx,
    output logic          fas_frame,
    output logic          ts0_end,
    output logic          frame_end
);
    localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_BITS - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

    logic [BW-1:0] bit_q;
    logic [SW-1:0] slot_q;
    logic          par_q;
    logic          bit_wrap;

    assign bit_wrap = (bit_q == BIT_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
            par_q  <= 1'b0;
        end else if (load) begin
            // The bit just taken completed slot 0 of an alignment-word frame.
            bit_q  <= '0;
            slot_q <= SW'(1);
            par_q  <= 1'b1;
        end else begin
            bit_q <= bit_wrap ? '0 : bit_q + 1'b1;
            if (bit_wrap) begin
                if (slot_q == SLOT_LAST) begin
                    slot_q <= '0;
                    par_q  <= ~par_q;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    assign bit_idx   = bit_q;
    assign slot_idx  = slot_q;
    assign fas_frame = par_q;
    assign ts0_end   = bit_wrap && (slot_q == '0);
    assign frame_end = bit_wrap && (slot_q == SLOT_LAST);
endmodule

// File: rtl/fa_pulse_stretch.sv
// Holds a single-cycle trigger high for LEN clocks.
module fa_pulse_stretch #(
    parameter int  LEN = 4,
    localparam int CW  = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam logic [CW-1:0] LOAD_VAL = CW'(LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/fa_align_fsm.sv
// Alignment controller: main group (hunt, confirm, lock with word-error
// count) plus a service-word error group.
module fa_align_fsm
    import frame_align_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk,
    input  logic frame_end,
    input  logic fas_frame,
    input  logic fas_hit,
    input  logic sw_good,
    input  logic alarm_bit,
    output logic load,
    output logic aligned,
    output logic fault_trig,
    output logic sync_pulse,
    output logic dist_alarm
);
    align_state_t st_q, st_d;
    sw_state_t    sw_q, sw_d;
    logic         dist_q, dist_d;
    logic         fas_chk, sw_chk;

    assign fas_chk = chk && fas_frame;
    assign sw_chk  = chk && !fas_frame;

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            sw_q   <= SW_OK;
            dist_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            sw_q   <= sw_d;
            dist_q <= dist_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        sw_d = sw_q;
        unique case (st_q)
            ST_HUNT: begin
                if (fas_hit) st_d = ST_GOT_FAS;
            end
            ST_GOT_FAS: begin
                if (sw_chk) st_d = sw_good ? ST_GOT_SW : ST_HUNT;
            end
            ST_GOT_SW: begin
                if (fas_chk) st_d = fas_hit ? ST_LOCK0 : ST_HUNT;
            end
            ST_LOCK0, ST_LOCK1, ST_LOCK2: begin
                if (fas_chk) begin
                    if (fas_hit) begin
                        st_d = ST_LOCK0;
                    end else begin
                        unique case (st_q)
                            ST_LOCK0: st_d = ST_LOCK1;
                            ST_LOCK1: st_d = ST_LOCK2;
                            default:  st_d = ST_HUNT;
                        endcase
                    end
                end else if (sw_chk) begin
                    if (sw_good) begin
                        sw_d = SW_OK;
                    end else begin
                        sw_d = (sw_q == SW_OK) ? SW_ERR1 : SW_ERR2;
                    end
                    if (sw_d == SW_ERR2) st_d = ST_HUNT;
                end
            end
            default: st_d = ST_HUNT;
        endcase
        if (!is_locked(st_d)) sw_d = SW_OK;

        if (!is_locked(st_d)) begin
            dist_d = 1'b0;
        end else if (sw_chk && is_locked(st_q)) begin
            dist_d = alarm_bit;
        end else begin
            dist_d = dist_q;
        end
    end

    // Outputs
    always_comb begin
        load       = 1'b0;
        fault_trig = 1'b0;
        aligned    = 1'b0;
        unique case (st_q)
            ST_HUNT: begin
                load       = fas_hit;
                fault_trig = fas_chk;
            end
            ST_GOT_FAS: begin
            end
            ST_GOT_SW: begin
                fault_trig = fas_chk && !fas_hit;
            end
            ST_LOCK0, ST_LOCK1, ST_LOCK2: begin
                aligned    = 1'b1;
                fault_trig = fas_chk && !fas_hit;
            end
            default: begin
            end
        endcase
        sync_pulse = aligned && frame_end && !fas_frame;
        dist_alarm = dist_q;
    end
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner #(
    parameter int                   SLOTS     = 32,
    parameter int                   SLOT_BITS = 8,
    parameter int                   FAULT_LEN = 4,
    parameter logic [SLOT_BITS-2:0] FAS_WORD  = 7'b0011011,
    localparam int                  BW        = $clog2(SLOT_BITS),
    localparam int                  SW        = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] slot_idx,
    output logic          fas_frame,
    output logic          sync_pulse,
    output logic          fault_pulse,
    output logic          lof,
    output logic          dist_alarm
);
    logic fas_hit, sw_good, alarm_bit;
    logic ts0_end, frame_end, load, aligned, fault_trig;

    fa_ts0_window #(
        .SLOT_BITS (SLOT_BITS),
        .FAS_WORD  (FAS_WORD)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .fas_hit   (fas_hit),
        .sw_good   (sw_good),
        .alarm_bit (alarm_bit)
    );

    fa_position #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS)
    ) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .bit_idx   (bit_idx),
        .slot_idx  (slot_idx),
        .fas_frame (fas_frame),
        .ts0_end   (ts0_end),
        .frame_end (frame_end)
    );

    fa_align_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk        (ts0_end),
        .frame_end  (frame_end),
        .fas_frame  (fas_frame),
        .fas_hit    (fas_hit),
        .sw_good    (sw_good),
        .alarm_bit  (alarm_bit),
        .load       (load),
        .aligned    (aligned),
        .fault_trig (fault_trig),
        .sync_pulse (sync_pulse),
        .dist_alarm (dist_alarm)
    );

    fa_pulse_stretch #(
        .LEN (FAULT_LEN)
    ) u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (fault_trig),
        .pulse (fault_pulse)
    );

    assign lof = !aligned;
endmodule

// File: rtl/frame_aligner_chk.sv
module frame_aligner_chk #(
    parameter int  SLOTS     = 32,
    parameter int  SLOT_BITS = 8,
    parameter int  FAULT_LEN = 4,
    localparam int BW        = $clog2(SLOT_BITS),
    localparam int SW        = $clog2(SLOTS),
    localparam int RW        = $clog2(FAULT_LEN + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [BW-1:0] bit_idx,
    input logic [SW-1:0] slot_idx,
    input logic          fas_frame,
    input logic          sync_pulse,
    input logic          fault_pulse,
    input logic          lof,
    input logic          dist_alarm
);
    localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_BITS - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
    localparam logic [RW-1:0] RUN_FULL  = RW'(FAULT_LEN);

    logic [RW-1:0] run_q;
    logic [BW-1:0] bit_exp;
    logic [SW-1:0] slot_exp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (fault_pulse) begin
            run_q <= (run_q == RUN_FULL) ? run_q : run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_exp  <= '0;
            slot_exp <= '0;
        end else begin
            bit_exp  <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
            slot_exp <= (bit_idx != BIT_LAST) ? slot_idx :
                        (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;
        end
    end

    assert_sync_only_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> !lof);

    assert_sync_position_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> (slot_idx == SLOT_LAST && bit_idx == BIT_LAST && !fas_frame));

    assert_fault_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> (run_q < RUN_FULL));

    assert_fault_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_pulse) |-> (run_q == RUN_FULL));

    assert_lof_at_ts0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lof) || $fell(lof)) |-> (bit_idx == '0 && slot_idx == SW'(1)));

    assert_dist_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lof |-> !dist_alarm);

    assert_pos_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lof && $past(!lof)) |-> (bit_idx == bit_exp && slot_idx == slot_exp));

    assert_parity_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lof && $past(!lof) && bit_idx == '0 && slot_idx == '0)
            |-> (fas_frame != $past(fas_frame)));
endmodule

bind frame_aligner frame_aligner_chk #(
    .SLOTS     (SLOTS),
    .SLOT_BITS (SLOT_BITS),
    .FAULT_LEN (FAULT_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_idx     (bit_idx),
    .slot_idx    (slot_idx),
    .fas_frame   (fas_frame),
    .sync_pulse  (sync_pulse),
    .fault_pulse (fault_pulse),
    .lof         (lof),
    .dist_alarm  (dist_alarm)
);

// File: tb/sim_frame_aligner.sv
`timescale 1ns/1ps
module sim_frame_aligner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b1;
    logic [2:0] bit_idx;
    logic [4:0] slot_idx;
    logic       fas_frame, sync_pulse, fault_pulse, lof, dist_alarm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int fault_cnt, first_fault, sync_cnt, sync_last, lof_end, dist_end, pos_err, lof_low;

    frame_aligner u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .bit_idx     (bit_idx),
        .slot_idx    (slot_idx),
        .fas_frame   (fas_frame),
        .sync_pulse  (sync_pulse),
        .fault_pulse (fault_pulse),
        .lof         (lof),
        .dist_alarm  (dist_alarm)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Slot 0 contents: good word, corrupted word (position 3 flipped), or
    // a service word {1, sw bit, alarm bit, 1,1,1,1,1}.
    task automatic send_frame(input bit is_fas, input bit good, input bit alarm);
        logic [7:0] ts0;
        if (is_fas) ts0 = good ? 8'b1001_1011 : 8'b1000_1011;
        else        ts0 = {1'b1, good, alarm, 5'b11111};
        fault_cnt = 0; first_fault = -1; sync_cnt = 0; sync_last = 0; pos_err = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            din = (i < 8) ? ts0[7-i] : 1'b1;
            #1;
            if (fault_pulse) begin
                fault_cnt++;
                if (first_fault < 0) first_fault = i;
            end
            if (sync_pulse) begin
                sync_cnt++;
                if (i == 255) sync_last = 1;
            end
            if (slot_idx != 5'(i / 8) || bit_idx != 3'(i % 8) || fas_frame != is_fas)
                pos_err++;
            if (i == 255) begin
                lof_end  = int'(lof);
                dist_end = int'(dist_alarm);
            end
        end
    endtask

    task automatic send_ones(input int nbits);
        fault_cnt = 0; sync_cnt = 0; lof_low = 0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            din = 1'b1;
            #1;
            if (fault_pulse) fault_cnt++;
            if (sync_pulse)  sync_cnt++;
            if (!lof)        lof_low++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din   = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic acquire();
        send_frame(1, 1, 0);
        send_frame(0, 1, 0);
        check("R2 position after hunt lock", pos_err, 0);
        check("R3 lof before confirmation", lof_end, 1);
        send_frame(1, 1, 0);
        check("R3 lof after confirmation", lof_end, 0);
        check("R6 no fault at confirming check", fault_cnt, 0);
        send_frame(0, 1, 0);
        check("R4 sync pulse count", sync_cnt, 1);
        check("R4 sync pulse at last bit", sync_last, 1);
        check("R10 position while aligned", pos_err, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 lof in reset", int'(lof), 1);
        check("R1 sync/fault/alarm in reset", int'({sync_pulse, fault_pulse, dist_alarm}), 0);
        check("R1 position in reset", int'({slot_idx, bit_idx, fas_frame}), 0);
        rst_n = 1'b1;
    endtask

    task automatic test_hunt_idle();
        do_reset();
        send_ones(512);
        check("R6 fault samples over 512 bits unaligned", fault_cnt, 4);
        check("R4 no sync while unaligned", sync_cnt, 0);
        check("R3 stays unaligned on idle", lof_low, 0);
        send_ones(1024);
        check("R6 fault samples over 1024 bits unaligned", fault_cnt, 8);
    endtask

    task automatic test_restart();
        do_reset();
        send_frame(1, 1, 0);
        send_frame(0, 0, 0);
        check("R3 bad service word in confirmation", lof_end, 1);
        send_frame(1, 1, 0);
        send_frame(0, 1, 0);
        check("R3 still confirming", lof_end, 1);
        send_frame(1, 1, 0);
        check("R3 aligned after restarted search", lof_end, 0);
        send_frame(0, 1, 0);
        check("R2 position after restarted search", pos_err, 0);
    endtask

    task automatic test_fas_errors();
        do_reset();
        acquire();
        send_frame(1, 0, 0);
        check("R5 fault length on bad word", fault_cnt, 4);
        check("R5 fault start bit", first_fault, 8);
        check("R7 one bad word keeps alignment", lof_end, 0);
        send_frame(0, 1, 0);
        check("R4 sync continues after one bad word", sync_cnt, 1);
        send_frame(1, 1, 0);
        check("R5 no fault on good word", fault_cnt, 0);
        send_frame(0, 1, 0);
        send_frame(1, 0, 0);
        send_frame(0, 1, 0);
        send_frame(1, 0, 0);
        check("R7 two in a row after reset of count", lof_end, 0);
        send_frame(0, 1, 0);
        send_frame(1, 0, 0);
        check("R7 third bad word in a row", lof_end, 1);
        check("R5 fault on losing word", fault_cnt, 4);
    endtask

    task automatic test_sw_errors();
        do_reset();
        acquire();
        send_frame(1, 1, 0);
        send_frame(0, 0, 0);
        check("R8 one bad service word", lof_end, 0);
        send_frame(1, 1, 0);
        send_frame(0, 1, 0);
        send_frame(1, 1, 0);
        send_frame(0, 0, 0);
        check("R8 count restarted by good service word", lof_end, 0);
        send_frame(1, 1, 0);
        send_frame(0, 0, 0);
        check("R8 second bad service word in a row", lof_end, 1);
    endtask

    task automatic test_alarm();
        do_reset();
        acquire();
        send_frame(1, 1, 0);
        send_frame(0, 1, 1);
        check("R9 alarm bit set", dist_end, 1);
        send_frame(1, 1, 0);
        check("R9 word frame leaves alarm", dist_end, 1);
        send_frame(0, 1, 0);
        check("R9 alarm bit clear", dist_end, 0);
        send_frame(1, 1, 0);
        send_frame(0, 1, 1);
        check("R9 alarm bit set again", dist_end, 1);
        send_frame(1, 0, 0);
        send_frame(0, 1, 1);
        send_frame(1, 0, 0);
        send_frame(0, 1, 1);
        send_frame(1, 0, 0);
        check("R7 loss in alarm run", lof_end, 1);
        check("R9 alarm cleared on loss", dist_end, 0);
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        test_reset();
        test_hunt_idle();
        do_reset();
        acquire();
        test_restart();
        test_fas_errors();
        test_sw_errors();
        test_alarm();
        finish_run();
    end
endmodule